// File: doc/BRIEF.md
# Four-Phase Register Capture Port

This block is the target side of a narrow register access port. A master drives one 16-bit input bus together with four level strobes. One strobe loads the bus into an internal address latch. A second strobe loads the bus into a write-data latch. The third commits the latched data to the latched address. The fourth returns the contents of the latched address on a 16-bit output. Each strobe is acknowledged on a single `ack` line with a full request/acknowledge handshake. A write takes three handshakes: address, data, commit. A read takes two: address, then read.

The register space behind the port is a small array of `NUM_REGS` words at addresses `0` to `NUM_REGS-1`. Each word has a defined reset value. Addresses at or above `NUM_REGS` are unmapped. The latched address and data persist between handshakes, so a master can repeat a command without capturing them again.

Top module: `cfg_capture_port`

## Requirements
- R1: While `rst` is high and right after it, `ack` is 0 and `data_out` is 0x0000. Register `i` (0 ≤ i < `NUM_REGS`) resets to 0xA000 + i·0x0101.
- R2: When exactly one strobe is high at a rising edge while the port is idle, `ack` goes high `ACK_DLY` clock edges later (default 2). With a strobe raised between edges, `ack` is first seen high on the (`ACK_DLY`+1)-th following falling edge.
- R3: A capture-address handshake latches `data_in` as the address. A capture-data handshake latches `data_in` as the write value.
- R4: A write handshake stores the latched data at the latched address. The value on `data_in` during the write handshake has no effect.
- R5: A read handshake places the word at the latched address on `data_out` no later than the edge where `ack` rises. `data_out` holds that value for as long as `ack` is high.
- R6: `ack` stays high while the acknowledged strobe stays high. It drops at the first rising edge at which that strobe is sampled low.
- R7: If more than one strobe is high at once, the port performs no action and raises no `ack` until all four strobes are low.
- R8: A write to an unmapped address changes no register. A read of an unmapped address returns 0x0000.
- R9: The latched address and write data persist across handshakes until they are captured again. A repeated write or read uses the values captured earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 16 | Address or write value, depending on the strobe |
| cap_addr | input | 1 | Strobe: latch `data_in` as the address |
| cap_data | input | 1 | Strobe: latch `data_in` as the write value |
| rd | input | 1 | Strobe: read the latched address |
| wr | input | 1 | Strobe: write the latched data to the latched address |
| ack | output | 1 | Handshake acknowledge, common to all strobes |
| data_out | output | 16 | Read value, valid while `ack` is high after a read |

## Verification
The assertions assume the master follows the four-phase protocol: it holds a strobe until `ack` rises and does not raise a new strobe until `ack` has fallen. The multi-strobe property assumes only that overlapping strobes draw no acknowledge. The stimulus changes inputs only on falling clock edges and waits for `ack` to rise and fall before the next strobe. The only departure from the protocol is a deliberate one: two strobes raised at once, released one at a time, to exercise the drain behaviour.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int NUM_OPS = 4;

  // Bit positions inside the strobe vector; the controller indexes by these.
  localparam int OP_ADDR = 0;
  localparam int OP_DATA = 1;
  localparam int OP_RD   = 2;
  localparam int OP_WR   = 3;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_BUSY  = 2'd1,
    HS_ACK   = 2'd2,
    HS_DRAIN = 2'd3
  } hs_state_t;
endpackage

// File: rtl/cap_hs_ctrl.sv
module cap_hs_ctrl
  import cap_pkg::*;
#(
  parameter int ACK_DLY = 2,
  localparam int CNT_W = $clog2(ACK_DLY + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OPS-1:0] strb,
  output logic               ack,
  output logic [NUM_OPS-1:0] fire,
  output logic               ld_rdata
);

  hs_state_t          state_q;
  logic [NUM_OPS-1:0] op_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               single;
  logic               any_hi;
  logic               ack_set;

  assign any_hi   = |strb;
  assign single   = any_hi && ((strb & (strb - 1'b1)) == '0);
  assign fire     = (state_q == HS_IDLE && single) ? strb : '0;
  assign ack_set  = (state_q == HS_BUSY) && (cnt_q == CNT_W'(ACK_DLY)) && (strb == op_q);
  assign ld_rdata = ack_set && op_q[OP_RD];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_IDLE;
      op_q    <= '0;
      cnt_q   <= '0;
      ack     <= 1'b0;
    end else begin
      case (state_q)
        HS_IDLE: begin
          if (single) begin
            state_q <= HS_BUSY;
            op_q    <= strb;
            cnt_q   <= CNT_W'(1);
          end else if (any_hi) begin
            state_q <= HS_DRAIN;
          end
        end
        HS_BUSY: begin
          if (strb != op_q) begin
            state_q <= HS_DRAIN;
          end else if (ack_set) begin
            state_q <= HS_ACK;
            ack     <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        HS_ACK: begin
          if ((strb & op_q) == '0) begin
            ack     <= 1'b0;
            state_q <= any_hi ? HS_DRAIN : HS_IDLE;
          end
        end
        default: begin
          if (!any_hi) state_q <= HS_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/cap_regfile.sv
module cap_regfile #(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 16,
  parameter int          NUM_REGS = 8,
  parameter logic [15:0] RST_BASE = 16'hA000,
  parameter logic [15:0] RST_STEP = 16'h0101,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              mapped;
  logic [IDX_W-1:0]  idx;

  assign mapped = (addr < ADDR_W'(NUM_REGS));
  assign idx    = addr[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] INIT = DATA_W'(RST_BASE + 16'(g) * RST_STEP);
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= INIT;
      else if (we && mapped && idx == IDX_W'(g)) regs[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (mapped) rdata <= regs[idx];
    else             rdata <= '0;
  end

endmodule

// File: rtl/cfg_capture_port.sv
module cfg_capture_port
  import cap_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int ACK_DLY  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  input  logic              cap_addr,
  input  logic              cap_data,
  input  logic              rd,
  input  logic              wr,
  output logic              ack,
  output logic [DATA_W-1:0] data_out
);

  logic [NUM_OPS-1:0] strb;
  logic [NUM_OPS-1:0] fire;
  logic               ld_rdata;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata;

  always_comb begin
    strb          = '0;
    strb[OP_ADDR] = cap_addr;
    strb[OP_DATA] = cap_data;
    strb[OP_RD]   = rd;
    strb[OP_WR]   = wr;
  end

  cap_hs_ctrl #(.ACK_DLY(ACK_DLY)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .ack      (ack),
    .fire     (fire),
    .ld_rdata (ld_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      data_out <= '0;
    end else begin
      if (fire[OP_ADDR]) addr_q  <= ADDR_W'(data_in);
      if (fire[OP_DATA]) wdata_q <= data_in;
      if (ld_rdata)      data_out <= rdata;
    end
  end

  cap_regfile #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr_q),
    .we    (fire[OP_WR]),
    .wdata (wdata_q),
    .rdata (rdata)
  );

endmodule

// File: rtl/cfg_capture_port_chk.sv
module cfg_capture_port_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cap_addr,
  input logic              cap_data,
  input logic              rd,
  input logic              wr,
  input logic              ack,
  input logic [DATA_W-1:0] data_out
);

  logic [3:0] s;
  assign s = {wr, rd, cap_data, cap_addr};

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !ack)
    else $error("R1: ack high after reset");

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $countones(s) == 1)
    else $error("R2: ack rose without exactly one strobe");

  a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(ack)) |-> $stable(data_out))
    else $error("R5: data_out moved while ack high");

  a_r6_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (ack && s == 4'b0000) |=> !ack)
    else $error("R6: ack held with no strobe");

  a_r7_multi_no_ack: assert property (@(posedge clk) disable iff (rst)
    (!ack && $countones(s) > 1) |=> !ack)
    else $error("R7: ack raised on overlapping strobes");

endmodule

bind cfg_capture_port cfg_capture_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cap_addr (cap_addr),
  .cap_data (cap_data),
  .rd       (rd),
  .wr       (wr),
  .ack      (ack),
  .data_out (data_out)
);

// File: tb/tb_cfg_capture_port.sv
module tb_cfg_capture_port;
  localparam int CLK_PERIOD = 10;
  localparam int ACK_DLY    = 2;
  localparam int NUM_REGS   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] data_in = '0;
  logic [3:0]  sdrv = '0;   // {wr, rd, cap_data, cap_addr}
  logic        ack;
  logic [15:0] data_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [NUM_REGS];
  logic [15:0] exp_q [$];
  logic        ack_prev = 1'b0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_capture_port #(.NUM_REGS(NUM_REGS), .ACK_DLY(ACK_DLY)) dut (
    .clk(clk), .rst(rst), .data_in(data_in),
    .cap_addr(sdrv[0]), .cap_data(sdrv[1]), .rd(sdrv[2]), .wr(sdrv[3]),
    .ack(ack), .data_out(data_out)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: on each rising ack during a read, compare data_out with the queue head (R5).
  always @(negedge clk) begin
    if (!rst && ack && !ack_prev && sdrv[2]) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected read", data_out, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(data_out == e, "R5 read data", data_out, e);
      end
    end
    ack_prev = ack;
  end

  task automatic hs(input int op, input logic [15:0] din);
    int n;
    @(negedge clk);
    data_in  = din;
    sdrv     = '0;
    sdrv[op] = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!ack && n < 20);
    check(n == ACK_DLY + 1, "R2 ack latency", n, ACK_DLY + 1);
    @(negedge clk);
    check(ack == 1'b1, "R6 ack held", ack, 1);
    sdrv    = '0;
    data_in = 16'hDEAD;
    @(negedge clk);
    check(ack == 1'b0, "R6 ack drop", ack, 0);
  endtask

  task automatic do_read(input logic [15:0] exp);
    exp_q.push_back(exp);
    hs(2, 16'h5A5A);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_REGS; i++) model[i] = 16'hA000 + 16'(i) * 16'h0101;
    repeat (3) @(negedge clk);
    check(ack == 1'b0, "R1 ack in reset", ack, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ack == 1'b0, "R1 ack after reset", ack, 0);
    check(data_out == 16'h0, "R1 data_out after reset", data_out, 0);

    // R1 reset values, R5 read path
    hs(0, 16'h0002); do_read(model[2]);
    hs(0, 16'h0007); do_read(model[7]);

    // R3 capture, R4 write with garbage data_in
    hs(0, 16'h0003); hs(1, 16'h1234); hs(3, 16'hFFFF);
    model[3] = 16'h1234;
    do_read(model[3]);

    // R9 persistence: new address, no data capture, repeat write and reads
    hs(0, 16'h0005); hs(3, 16'h0F0F);
    model[5] = 16'h1234;
    do_read(model[5]);
    do_read(model[5]);

    // R8 unmapped write and read
    hs(0, 16'h0040); hs(1, 16'hBEEF); hs(3, 16'h0000);
    do_read(16'h0000);
    hs(0, 16'h0008); do_read(16'h0000);
    hs(0, 16'h0000); do_read(model[0]);

    // R7 overlapping strobes: nothing captured, no ack until all low
    @(negedge clk);
    data_in = 16'h0006;
    sdrv = 4'b1001;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(ack == 1'b0, "R7 no ack overlap", ack, 0);
    end
    sdrv = 4'b1000;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(ack == 1'b0, "R7 no ack draining", ack, 0);
    end
    sdrv = '0;
    @(negedge clk);
    do_read(model[0]);   // R7: address stays 0, no write happened

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule